// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block sends characters on an asynchronous serial line. Each character is framed by a low start bit and a high stop bit, and carries either 8 or 9 data bits. A waiting slot sits in front of the shift stage, so the producer can queue the next character while the current one is still going out. When the shift stage is empty, a queued character moves into it at once. When the shift stage is busy, the queued character moves in on the same clock edge that finishes the current stop bit, so back-to-back frames have no idle gap. A one-cycle baud tick from outside sets the bit pace. Two flags are kept, each gated by its own enable into an interrupt request: one shows that the waiting slot is empty, and one shows that the line has gone idle with nothing left to send.

Characters enter on a valid/ready port. `s_ready` is high exactly when the waiting slot is empty, and it also serves as the slot-empty status flag. Ready gives advice only; it does not block the producer. A beat that arrives while ready is low replaces the character that is waiting, and the frame on the line is left alone. A producer that wants every character delivered must send only while ready is high. The width is chosen per character by `wide_mode`. The ninth bit comes from `s_bit8`. Both are sampled when the character moves into the shift stage, not when it is written.

Top module: `uart_tx_dbuf`

## Requirements
- R1: After reset, `txd` is 1, `s_ready` is 1, `tx_done` is 0, and `irq_done` is 0. `irq_empty` equals `ie_empty`.
- R2: If the shift stage is idle, a beat accepted at clock edge E moves into it at edge E+1, and `txd` shows the start bit (0) from E+1 on.
- R3: A frame is sent as a 0 start bit, then the data bits least significant first, then a 1 stop bit. Each bit lasts from one baud tick edge to the next.
- R4: With `wide_mode`=0 a frame has 10 bits. With `wide_mode`=1 it has 11 bits, and the value of `s_bit8` at the moment of transfer is sent after data bit 7.
- R5: If a character is waiting when the baud tick that ends a stop bit arrives, it moves into the shift stage on that same edge, and its start bit follows with no idle bit.
- R6: `s_ready` goes to 0 on the edge after an accepted beat. It returns to 1 on the edge where the waiting character moves into the shift stage, unless a new beat is accepted on that same edge.
- R7: A beat accepted while `s_ready` is 0 replaces the waiting character. The frame being sent is unchanged, and `txd` changes only on baud tick edges or loads.
- R8: `tx_done` is set on the edge that ends a stop bit when no character is waiting and no beat is accepted on that edge. It is not set between back-to-back frames.
- R9: `tx_done` is cleared on the edge after an accepted beat or a `done_clr` pulse. `done_clr` wins over a completion on the same edge.
- R10: `irq_done` equals `tx_done` AND `ie_done`, and `irq_empty` equals `s_ready` AND `ie_empty`.
- R11: While no frame is being sent, `txd` stays 1 and baud ticks have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wide_mode | input | 1 | 1 selects 9 data bits, 0 selects 8; sampled at transfer |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| s_valid | input | 1 | Write strobe for a character |
| s_ready | output | 1 | Waiting slot empty (status and ready) |
| s_data | input | 8 | Data bits 7..0 of the character |
| s_bit8 | input | 1 | Ninth data bit; sampled at transfer |
| done_clr | input | 1 | Clears the transmit-complete flag |
| ie_empty | input | 1 | Enable for the slot-empty interrupt |
| ie_done | input | 1 | Enable for the transmit-complete interrupt |
| txd | output | 1 | Serial line, idle high |
| tx_done | output | 1 | Transmit-complete flag |
| irq_empty | output | 1 | Slot-empty interrupt request |
| irq_done | output | 1 | Transmit-complete interrupt request |

## Verification
The key overlap is a new write landing on the same edge as the baud tick that ends a stop bit while another character is already waiting. On that edge the waiting character must move into the shift stage and the new one must take its place. A directed case sets this up by queuing a character, overwriting it, and then writing a third one on exactly the final tick. It is judged by a line decoder that expects the first, the overwritten-in and the third character in that order, with no idle bit between them, and by `s_ready` staying low and `tx_done` staying clear across that edge. A second directed case pulses `done_clr` on the completing tick, and randomized phases with tick rates from every cycle to every fourth cycle mix both overlaps with ordinary traffic.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  // Width of the base character; the optional ninth bit sits above it.
  localparam int unsigned UTX_DATA_W = 8;

  // Width selection as it is seen on the mode pin.
  typedef enum logic [0:0] {
    FMT_NARROW = 1'b0,
    FMT_WIDE   = 1'b1
  } frame_fmt_e;

  // Number of line bits for a given base width and format.
  function automatic int unsigned frame_len(input int unsigned base_w, input frame_fmt_e fmt);
    return base_w + 2 + ((fmt == FMT_WIDE) ? 1 : 0);
  endfunction

endpackage

// File: rtl/uart_tx_hold.sv
// Waiting slot in front of the shift stage. A write always lands here;
// a take empties it unless a write arrives on the same edge.
module uart_tx_hold #(
  parameter int unsigned DATA_W = uart_tx_pkg::UTX_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] data_q
);

  logic              full_q;
  logic [DATA_W-1:0] slot_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
    end else if (wr_en) begin
      full_q <= 1'b1;
    end else if (take) begin
      full_q <= 1'b0;
    end
  end

  // Data needs no reset: it is only used while full_q is set.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      slot_q <= wr_data;
    end
  end

  assign full   = full_q;
  assign data_q = slot_q;

endmodule

// File: rtl/uart_tx_shreg.sv
// Shift stage. It is filled with ones at rest, so bit 0 drives the line
// directly. A down-counter of remaining bit periods marks it busy.
module uart_tx_shreg #(
  parameter int unsigned DATA_W = uart_tx_pkg::UTX_DATA_W,
  parameter bit          EXT_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              ld_bit8,
  input  logic              ld_wide,
  input  logic              tick,
  output logic              line,
  output logic              busy,
  output logic              last_tick
);

  import uart_tx_pkg::*;

  localparam int unsigned SR_W  = frame_len(DATA_W, EXT_EN ? FMT_WIDE : FMT_NARROW);
  localparam int unsigned CNT_W = $clog2(SR_W + 1);

  logic [SR_W-1:0]  sr_q;
  logic [CNT_W-1:0] cnt_q;
  logic [SR_W-1:0]  frame;
  logic [CNT_W-1:0] ld_len;

  generate
    if (EXT_EN) begin : g_ext
      // In narrow format the spare slot is a second one that never leaves,
      // because the count stops one bit short.
      logic ext_bit;
      assign ext_bit = (ld_wide == FMT_WIDE) ? ld_bit8 : 1'b1;
      assign frame   = {1'b1, ext_bit, ld_data, 1'b0};
      assign ld_len  = (ld_wide == FMT_WIDE) ? CNT_W'(SR_W) : CNT_W'(SR_W - 1);
    end else begin : g_base
      logic unused_mode;
      assign unused_mode = ^{ld_wide, ld_bit8};
      assign frame  = {1'b1, ld_data, 1'b0};
      assign ld_len = CNT_W'(SR_W);
    end
  endgenerate

  assign busy      = (cnt_q != '0);
  assign last_tick = busy && tick && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_q  <= '1;
      cnt_q <= '0;
    end else if (load) begin
      sr_q  <= frame;
      cnt_q <= ld_len;
    end else if (busy && tick) begin
      sr_q  <= {1'b1, sr_q[SR_W-1:1]};
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign line = sr_q[0];

endmodule

// File: rtl/uart_tx_flags.sv
// Completion flag and the two gated interrupt requests.
module uart_tx_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_end,
  input  logic waiting,
  input  logic wr_en,
  input  logic clr,
  input  logic slot_empty,
  input  logic ie_empty,
  input  logic ie_done,
  output logic done,
  output logic irq_empty,
  output logic irq_done
);

  logic done_q;
  logic set_done;
  logic clr_done;

  // A write on the closing edge means a character is queued, so the
  // line is not going idle.
  assign set_done = stop_end && !waiting && !wr_en;
  assign clr_done = wr_en || clr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else if (clr_done) begin
      done_q <= 1'b0;
    end else if (set_done) begin
      done_q <= 1'b1;
    end
  end

  assign done      = done_q;
  assign irq_done  = done_q && ie_done;
  assign irq_empty = slot_empty && ie_empty;

endmodule

// File: rtl/uart_tx_dbuf.sv
// Double-buffered serial transmitter top.
module uart_tx_dbuf #(
  parameter int unsigned DATA_W = uart_tx_pkg::UTX_DATA_W,
  parameter bit          EXT_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wide_mode,
  input  logic              baud_tick,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_bit8,
  input  logic              done_clr,
  input  logic              ie_empty,
  input  logic              ie_done,
  output logic              txd,
  output logic              tx_done,
  output logic              irq_empty,
  output logic              irq_done
);

  logic              hold_full;
  logic [DATA_W-1:0] hold_data;
  logic              sh_busy;
  logic              sh_last;
  logic              xfer;

  // Move the waiting character when the shift stage is empty, or on the
  // edge that finishes the stop bit now on the line.
  assign xfer = hold_full && (!sh_busy || sh_last);

  uart_tx_hold #(
    .DATA_W (DATA_W)
  ) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (s_valid),
    .wr_data (s_data),
    .take    (xfer),
    .full    (hold_full),
    .data_q  (hold_data)
  );

  uart_tx_shreg #(
    .DATA_W (DATA_W),
    .EXT_EN (EXT_EN)
  ) u_shreg (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (xfer),
    .ld_data   (hold_data),
    .ld_bit8   (s_bit8),
    .ld_wide   (wide_mode),
    .tick      (baud_tick),
    .line      (txd),
    .busy      (sh_busy),
    .last_tick (sh_last)
  );

  uart_tx_flags u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .stop_end   (sh_last),
    .waiting    (hold_full),
    .wr_en      (s_valid),
    .clr        (done_clr),
    .slot_empty (!hold_full),
    .ie_empty   (ie_empty),
    .ie_done    (ie_done),
    .done       (tx_done),
    .irq_empty  (irq_empty),
    .irq_done   (irq_done)
  );

  assign s_ready = !hold_full;

endmodule

// File: rtl/uart_tx_dbuf_chk.sv
module uart_tx_dbuf_chk (
  input logic clk,
  input logic rst_n,
  input logic baud_tick,
  input logic s_valid,
  input logic s_ready,
  input logic done_clr,
  input logic ie_empty,
  input logic ie_done,
  input logic txd,
  input logic tx_done,
  input logic irq_empty,
  input logic irq_done,
  input logic busy,
  input logic hold_full,
  input logic last_tick
);

  // R2
  idle_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && hold_full) |=> (busy && !txd));

  // R5
  back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last_tick && hold_full) |=> (busy && !txd));

  // R6
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid |=> !s_ready);

  // R7
  line_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !baud_tick) |=> $stable(txd));

  // R8
  done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last_tick && !hold_full && !s_valid && !done_clr) |=> tx_done);

  // R9
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_clr || s_valid) |=> !tx_done);

  // R10
  irq_done_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_done |-> (tx_done && ie_done));

  // R10
  irq_empty_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_empty |-> (s_ready && ie_empty));

  // R11
  idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);

endmodule

bind uart_tx_dbuf uart_tx_dbuf_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .baud_tick (baud_tick),
  .s_valid   (s_valid),
  .s_ready   (s_ready),
  .done_clr  (done_clr),
  .ie_empty  (ie_empty),
  .ie_done   (ie_done),
  .txd       (txd),
  .tx_done   (tx_done),
  .irq_empty (irq_empty),
  .irq_done  (irq_done),
  .busy      (sh_busy),
  .hold_full (hold_full),
  .last_tick (sh_last)
);

// File: tb/uart_tx_dbuf_bench.sv
`timescale 1ns/1ps
module uart_tx_dbuf_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wide_mode = 1'b0;
  logic       baud_tick = 1'b0;
  logic       s_valid = 1'b0;
  logic       s_ready;
  logic [7:0] s_data = 8'h00;
  logic       s_bit8 = 1'b0;
  logic       done_clr = 1'b0;
  logic       ie_empty = 1'b0;
  logic       ie_done = 1'b0;
  logic       txd;
  logic       tx_done;
  logic       irq_empty;
  logic       irq_done;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  int unsigned wd = 0;
  bit          reported = 1'b0;
  bit          auto_tick = 1'b0;
  int unsigned div = 1;
  int unsigned divc = 0;
  bit          irq_watch = 1'b0;

  // Expected frames: {wide, bit8, data}
  logic [9:0] exp_q[$];

  always #2 clk = ~clk;

  uart_tx_dbuf u_uart_tx_dbuf (
    .clk       (clk),
    .rst_n     (rst_n),
    .wide_mode (wide_mode),
    .baud_tick (baud_tick),
    .s_valid   (s_valid),
    .s_ready   (s_ready),
    .s_data    (s_data),
    .s_bit8    (s_bit8),
    .done_clr  (done_clr),
    .ie_empty  (ie_empty),
    .ie_done   (ie_done),
    .txd       (txd),
    .tx_done   (tx_done),
    .irq_empty (irq_empty),
    .irq_done  (irq_done)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  // Advance one cycle; pulses drop, the tick follows the divider if enabled.
  task automatic step();
    @(posedge clk);
    #1;
    s_valid  = 1'b0;
    done_clr = 1'b0;
    if (auto_tick) begin
      baud_tick = (divc == 0);
      divc = (divc + 1 >= div) ? 0 : divc + 1;
    end else begin
      baud_tick = 1'b0;
    end
  endtask

  task automatic smp();
    @(negedge clk);
  endtask

  task automatic mtick();
    step();
    baud_tick = 1'b1;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) mtick();
  endtask

  task automatic put(input logic [7:0] d, input logic b8, input bit expect_it);
    step();
    s_valid = 1'b1;
    s_data  = d;
    s_bit8  = b8;
    if (expect_it) exp_q.push_back({wide_mode, b8, d});
  endtask

  // Line decoder: collects one bit after every tick edge once a start is seen.
  logic        tick_at_edge = 1'b0;
  bit          dec_on = 1'b0;
  int unsigned dec_n = 0;
  int unsigned dec_need = 0;
  logic [10:0] dec_bits;
  logic [9:0]  dec_head;

  always @(posedge clk) tick_at_edge <= baud_tick;

  always @(negedge clk) begin
    if (rst_n) begin
      if (dec_on) begin
        if (tick_at_edge) begin
          dec_bits[dec_n] = txd;
          dec_n++;
          if (dec_n == dec_need) begin
            dec_on = 1'b0;
            chk("R3 data bits", {24'h0, dec_bits[7:0]}, {24'h0, dec_head[7:0]});
            chk("R3 stop bit", {31'h0, dec_bits[dec_need-1]}, 32'h1);
            if (dec_head[9]) chk("R4 ninth bit", {31'h0, dec_bits[8]}, {31'h0, dec_head[8]});
          end
        end
      end else if (txd == 1'b0) begin
        if (exp_q.size() == 0) begin
          chk("R7 unexpected frame start", 32'h1, 32'h0);
        end else begin
          dec_head = exp_q.pop_front();
          dec_on   = 1'b1;
          dec_n    = 0;
          dec_need = dec_head[9] ? 10 : 9;
        end
      end
      if (irq_watch) begin
        chk("R10 irq_done gate", {31'h0, irq_done}, {31'h0, tx_done & ie_done});
        chk("R10 irq_empty gate", {31'h0, irq_empty}, {31'h0, s_ready & ie_empty});
      end
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      report();
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    // Reset
    repeat (3) step();
    smp();
    chk("R1 txd", {31'h0, txd}, 32'h1);
    chk("R1 ready", {31'h0, s_ready}, 32'h1);
    chk("R1 done", {31'h0, tx_done}, 32'h0);
    step(); rst_n = 1'b1;
    smp();
    chk("R1 txd after release", {31'h0, txd}, 32'h1);
    chk("R1 irq_empty off", {31'h0, irq_empty}, 32'h0);
    ie_empty = 1'b1; ie_done = 1'b1;
    #0.1;
    chk("R1 irq_empty on", {31'h0, irq_empty}, 32'h1);
    chk("R1 irq_done", {31'h0, irq_done}, 32'h0);

    // Idle load latency and ready pulse
    put(8'hA5, 1'b0, 1'b1);
    smp(); chk("R2 line before edge", {31'h0, txd}, 32'h1);
    step(); smp();
    chk("R6 ready low after write", {31'h0, s_ready}, 32'h0);
    chk("R2 line still idle", {31'h0, txd}, 32'h1);
    step(); smp();
    chk("R2 start bit", {31'h0, txd}, 32'h0);
    chk("R6 ready back after transfer", {31'h0, s_ready}, 32'h1);
    ticks(9);
    step(); smp();
    chk("R8 done not before stop ends", {31'h0, tx_done}, 32'h0);
    mtick();
    step(); smp();
    chk("R8 done set", {31'h0, tx_done}, 32'h1);
    chk("R10 irq_done on", {31'h0, irq_done}, 32'h1);
    ie_done = 1'b0; #0.1;
    chk("R10 irq_done masked", {31'h0, irq_done}, 32'h0);
    ie_done = 1'b1;

    // Explicit clear
    step(); done_clr = 1'b1;
    step(); smp();
    chk("R9 clear input", {31'h0, tx_done}, 32'h0);
    put(8'h3C, 1'b0, 1'b1);
    step(); step();
    ticks(10);
    step(); smp();
    chk("R8 done again", {31'h0, tx_done}, 32'h1);

    // Back-to-back, overwrite, and a write on the final tick
    put(8'h81, 1'b0, 1'b1);
    step(); smp();
    chk("R9 write clears done", {31'h0, tx_done}, 32'h0);
    step();
    ticks(3);
    put(8'h11, 1'b0, 1'b0);
    step(); smp();
    chk("R6 ready low while busy", {31'h0, s_ready}, 32'h0);
    put(8'h6E, 1'b0, 1'b1);
    ticks(6);
    step(); baud_tick = 1'b1; s_valid = 1'b1; s_data = 8'hD2;
    exp_q.push_back({wide_mode, 1'b0, 8'hD2});
    step(); smp();
    chk("R5 next start without gap", {31'h0, txd}, 32'h0);
    chk("R6 ready stays low with new write", {31'h0, s_ready}, 32'h0);
    chk("R8 no done between frames", {31'h0, tx_done}, 32'h0);
    ticks(10);
    step(); smp();
    chk("R5 third frame starts", {31'h0, txd}, 32'h0);
    chk("R6 ready after last transfer", {31'h0, s_ready}, 32'h1);
    ticks(10);
    step(); smp();
    chk("R8 done after final frame", {31'h0, tx_done}, 32'h1);

    // Nine-bit format; the ninth bit is taken at transfer
    wide_mode = 1'b1;
    put(8'h5A, 1'b1, 1'b1);
    step(); step();
    ticks(2);
    put(8'hC3, 1'b0, 1'b0);
    exp_q.push_back({1'b1, 1'b1, 8'hC3});
    step(); s_bit8 = 1'b1;
    ticks(9);
    step(); smp();
    chk("R4 wide frame continues", {31'h0, txd}, 32'h0);
    ticks(11);
    step(); smp();
    chk("R4 eleven bit frames done", {31'h0, tx_done}, 32'h1);
    wide_mode = 1'b0;

    // Clear on the completing edge
    put(8'h0F, 1'b0, 1'b1);
    step(); step();
    ticks(9);
    step(); baud_tick = 1'b1; done_clr = 1'b1;
    step(); smp();
    chk("R9 clear beats completion", {31'h0, tx_done}, 32'h0);

    // Idle ticks do nothing
    ticks(5);
    step(); smp();
    chk("R11 line idle under ticks", {31'h0, txd}, 32'h1);
    chk("R11 done untouched", {31'h0, tx_done}, 32'h0);
    chk("R11 ready untouched", {31'h0, s_ready}, 32'h1);

    // Randomized traffic, writes only while ready
    irq_watch = 1'b1;
    auto_tick = 1'b1;
    for (int seg = 0; seg < 6; seg++) begin
      wide_mode = $urandom % 2;
      div  = 1 + ($urandom % 4);
      divc = 0;
      for (int n = 0; n < 12; n++) begin
        do begin
          step();
          ie_empty = $urandom % 2;
          ie_done  = $urandom % 2;
          if ($urandom % 16 == 0) done_clr = 1'b1;
        end while (!(s_ready && ($urandom % 3 == 0)));
        s_valid = 1'b1;
        s_data  = 8'($urandom);
        s_bit8  = wide_mode ? ^s_data : 1'b0;
        exp_q.push_back({wide_mode, s_bit8, s_data});
      end
      do step(); while (!tx_done);
      smp();
      chk("R8 done after random segment", {31'h0, tx_done}, 32'h1);
    end
    irq_watch = 1'b0;
    repeat (4) step();
    chk("R3 every frame delivered", exp_q.size(), 32'h0);
    report();
  end

endmodule